// File: doc/BRIEF.md
# Audio Master Clock Generator

This block derives the serial-audio clocks for a converter running as clock master. Its only time base is an external master clock, which runs at 256, 512 or 1024 times the sample rate fs. From it the block produces a bit clock at 32 or 64 times fs and a frame (word-select) clock at fs. It can also produce a divided copy of the master clock at 256, 128, 64 or 32 times fs. All three outputs are taken from one free-running counter that is clocked by the master clock. Each output is registered, so it has a 50 % duty cycle and cannot glitch.

The select and enable inputs are plain control pins. They are sampled and applied only at a frame boundary, which is the cycle where the counter wraps. While the power-up pin is low, every input is taken at once. While the power-up pin is low the counter is cleared and all generated clocks are held low. There is no data path and therefore no valid/ready interface.

Top module: `audio_clkgen`

## Requirements
- R1: The frame clock period in master-clock cycles follows in_ratio_i, a code that does not increase monotonically with the ratio: code 0 gives 256, code 1 gives 1024, code 2 gives 512 and code 3 also gives 512. The frame clock is low for the first half of each frame (left channel) and high for the second half (right channel).
- R2: The bit clock period is the frame length divided by 32 when bclk_rate_i is 0, or divided by 64 when bclk_rate_i is 1. The duty cycle is 50 %.
- R3: Every frame clock transition happens on the same master-clock edge as a falling edge of the bit clock.
- R4: When mco_en_i is 1, mco_o runs at (256 >> out_ratio_i) times fs. Its period is therefore frame length × 2^out_ratio_i / 256 master-clock cycles, at 50 % duty.
- R5: When the requested mco_o ratio is not below the input ratio (in_ratio_i 0 with out_ratio_i 0), mco_o is the master clock passed through unchanged: high in the high phase and low in the low phase.
- R6: While the applied mco_en_i is 0, mco_o stays low in both clock phases.
- R7: A change on in_ratio_i, bclk_rate_i, out_ratio_i or mco_en_i while running takes effect only after the frame in progress has completed with the old settings.
- R8: While pwr_up_i is 0, the counter is cleared and bclk_o, fclk_o and mco_o stay low. After pwr_up_i is raised, the first frame starts from count zero on the left channel, so the first frame clock rise comes half a frame later.
- R9: An asynchronous low on rst_ni drives all three outputs low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | External master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | 1 runs the generator; 0 holds all clocks low |
| in_ratio_i | input | 2 | Master clock to fs ratio code (0:256, 1:1024, 2:512, 3:512) |
| bclk_rate_i | input | 1 | Bit clock rate (0: 32fs, 1: 64fs) |
| out_ratio_i | input | 2 | Divided output rate code (0:256fs, 1:128fs, 2:64fs, 3:32fs) |
| mco_en_i | input | 1 | Enables the divided clock output |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock, low = left |
| mco_o | output | 1 | Divided or passed-through master clock |

## Verification
The hardest case to reach from the ports is a select change that arrives partway through a frame. It must leave the current frame intact and take over exactly at the wrap. The bench powers up at ratio 256 with a 32fs bit clock and waits 50 cycles, which puts it inside the left half of the first frame. It then switches to ratio 1024 with a 64fs bit clock. From the captured waveform it measures the remaining old half-frame, the new half-frame length and the bit clock period on each side of the boundary. The pass-through mode is checked by sampling mco_o separately in each phase of the master clock.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // base ratio exponent: 256fs
  localparam int ACG_BASE_L2 = 8;
  // lowest bit clock exponent: 32fs
  localparam int ACG_BCLK_L2 = 5;
  // largest ratio is 4x base (1024fs)
  localparam int ACG_CNT_W   = ACG_BASE_L2 + 2;
  localparam int ACG_TAP_W   = $clog2(ACG_CNT_W);

  typedef struct packed {
    logic [ACG_CNT_W-1:0] last;
    logic [ACG_TAP_W-1:0] frm_tap;
    logic [ACG_TAP_W-1:0] bclk_tap;
    logic [ACG_TAP_W-1:0] mco_tap;
    logic                 mco_pass;
    logic                 mco_en;
  } acg_cfg_t;

  // Turns the raw select pins into counter tap positions.
  function automatic acg_cfg_t acg_decode(input logic [1:0] in_sel,
                                          input logic       bsel,
                                          input logic [1:0] out_sel,
                                          input logic       en);
    acg_cfg_t c;
    int in_l2;
    int mco_l2;
    case (in_sel)
      2'd0:    in_l2 = ACG_BASE_L2;
      2'd1:    in_l2 = ACG_BASE_L2 + 2;
      default: in_l2 = ACG_BASE_L2 + 1;
    endcase
    mco_l2     = in_l2 - (ACG_BASE_L2 - int'(out_sel));
    c.last     = ACG_CNT_W'((1 << in_l2) - 1);
    c.frm_tap  = ACG_TAP_W'(in_l2 - 1);
    c.bclk_tap = ACG_TAP_W'(in_l2 - ACG_BCLK_L2 - int'(bsel) - 1);
    c.mco_pass = (mco_l2 <= 0);
    c.mco_tap  = c.mco_pass ? '0 : ACG_TAP_W'(mco_l2 - 1);
    c.mco_en   = en;
    return c;
  endfunction

endpackage

// File: rtl/acg_cfg_reg.sv
module acg_cfg_reg
  import audio_clkgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] in_ratio_i,
  input  logic       bclk_rate_i,
  input  logic [1:0] out_ratio_i,
  input  logic       mco_en_i,
  output acg_cfg_t   cfg_o
);

  acg_cfg_t cfg_q;
  acg_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = acg_decode(in_ratio_i, bclk_rate_i, out_ratio_i, mco_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= acg_decode(2'd0, 1'b0, 2'd0, 1'b0);
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/acg_counter.sv
module acg_counter
  import audio_clkgen_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_up_i,
  input  logic [ACG_CNT_W-1:0] last_i,
  output logic [ACG_CNT_W-1:0] cnt_o,
  output logic                 run_o,
  output logic                 wrap_o
);

  logic [ACG_CNT_W-1:0] cnt_q;
  logic                 run_q;

  assign wrap_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= pwr_up_i;
      if (!pwr_up_i || wrap_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);

  // R8
  pwrdn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> (cnt_q == '0 && !run_q));

endmodule

// File: rtl/acg_clk_taps.sv
module acg_clk_taps
  import audio_clkgen_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [ACG_CNT_W-1:0] cnt_i,
  input  logic [ACG_TAP_W-1:0] frm_tap_i,
  input  logic [ACG_TAP_W-1:0] bclk_tap_i,
  input  logic [ACG_TAP_W-1:0] mco_tap_i,
  input  logic                 mco_pass_i,
  input  logic                 mco_en_i,
  output logic                 bclk_o,
  output logic                 fclk_o,
  output logic                 mco_o
);

  logic bclk_q;
  logic fclk_q;
  logic div_q;
  logic gate_p;
  logic gate_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
      div_q  <= 1'b0;
      gate_p <= 1'b0;
    end else begin
      bclk_q <= run_i & cnt_i[bclk_tap_i];
      fclk_q <= run_i & cnt_i[frm_tap_i];
      div_q  <= run_i & mco_en_i & ~mco_pass_i & cnt_i[mco_tap_i];
      gate_p <= run_i & mco_en_i & mco_pass_i;
    end
  end

  // Gate enable moves only while the clock is low, so the AND cannot glitch.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_n <= 1'b0;
    else         gate_n <= gate_p;
  end

  assign bclk_o = bclk_q;
  assign fclk_o = fclk_q;
  assign mco_o  = (clk_i & gate_n) | div_q;

  // R3
  frame_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fclk_q != $past(fclk_q)) |-> !bclk_q);

  // R6
  mco_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mco_en_i |=> (!div_q && !gate_p));

  // R5
  pass_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mco_pass_i |=> !div_q);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
(
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic [1:0] in_ratio_i,
  input  logic       bclk_rate_i,
  input  logic [1:0] out_ratio_i,
  input  logic       mco_en_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       mco_o
);

  acg_cfg_t             cfg_q;
  logic [ACG_CNT_W-1:0] cnt;
  logic                 run;
  logic                 wrap;
  logic                 load;

  assign load = !pwr_up_i || wrap;

  acg_cfg_reg u_cfg (
    .clk_i       (mclk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .in_ratio_i  (in_ratio_i),
    .bclk_rate_i (bclk_rate_i),
    .out_ratio_i (out_ratio_i),
    .mco_en_i    (mco_en_i),
    .cfg_o       (cfg_q)
  );

  acg_counter u_cnt (
    .clk_i    (mclk_i),
    .rst_ni   (rst_ni),
    .pwr_up_i (pwr_up_i),
    .last_i   (cfg_q.last),
    .cnt_o    (cnt),
    .run_o    (run),
    .wrap_o   (wrap)
  );

  acg_clk_taps u_taps (
    .clk_i      (mclk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .cnt_i      (cnt),
    .frm_tap_i  (cfg_q.frm_tap),
    .bclk_tap_i (cfg_q.bclk_tap),
    .mco_tap_i  (cfg_q.mco_tap),
    .mco_pass_i (cfg_q.mco_pass),
    .mco_en_i   (cfg_q.mco_en),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o),
    .mco_o      (mco_o)
  );

  // R7
  cfg_hold_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (pwr_up_i && !wrap) |=> $stable(cfg_q));

endmodule

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CAP_MAX    = 2200;
  localparam int WDOG       = 150000;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 1'b0;
  logic [1:0] in_sel = 2'd0;
  logic       bsel = 1'b0;
  logic [1:0] out_sel = 2'd0;
  logic       en = 1'b0;
  logic       bclk, fclk, mco;

  int checks = 0;
  int errors = 0;

  logic cap_b [CAP_MAX];
  logic cap_f [CAP_MAX];
  logic cap_m [CAP_MAX];

  always #(CLK_PERIOD/2) mclk = ~mclk;

  audio_clkgen dut_i (
    .mclk_i(mclk), .rst_ni(rst_n), .pwr_up_i(pwr), .in_ratio_i(in_sel),
    .bclk_rate_i(bsel), .out_ratio_i(out_sel), .mco_en_i(en),
    .bclk_o(bclk), .fclk_o(fclk), .mco_o(mco)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk); #3;
      cap_b[i] = bclk; cap_f[i] = fclk; cap_m[i] = mco;
    end
  endtask

  function automatic logic smp(input int which, input int i);
    case (which)
      0: return cap_b[i];
      1: return cap_f[i];
      default: return cap_m[i];
    endcase
  endfunction

  function automatic int find_edge(input int which, input int from, input bit rise);
    for (int i = from + 1; i < CAP_MAX; i++)
      if (smp(which, i) != smp(which, i-1) && smp(which, i) == rise) return i;
    return -100000;
  endfunction

  task automatic check_wave(input string req, input int which, input int from,
                            input int period, input int high);
    int r1 = find_edge(which, from, 1'b1);
    int f1 = find_edge(which, r1 < 0 ? CAP_MAX : r1, 1'b0);
    int r2 = find_edge(which, f1 < 0 ? CAP_MAX : f1, 1'b1);
    check(r2 - r1 == period, {req, " period"}, r2 - r1, period);
    check(f1 - r1 == high, {req, " high time"}, f1 - r1, high);
  endtask

  task automatic power_up(input logic [1:0] i, input logic b, input logic [1:0] o, input logic e);
    @(posedge mclk); #3;
    pwr = 1'b0; in_sel = i; bsel = b; out_sel = o; en = e;
    repeat (4) @(posedge mclk);
    #3; pwr = 1'b1;
  endtask

  function automatic int ratio(input logic [1:0] c);
    return (c == 2'd0) ? 256 : (c == 2'd1) ? 1024 : 512;
  endfunction

  task automatic t_reset();
    #(CLK_PERIOD*2 + 2);
    check({bclk, fclk, mco} == 3'b000, "R9 reset outputs", {bclk, fclk, mco}, 0);
    @(posedge mclk); #3; rst_n = 1'b1;
  endtask

  task automatic t_ratio(input logic [1:0] i, input logic b);
    int n = ratio(i);
    int bad = 0;
    power_up(i, b, 2'd0, 1'b0);
    capture(CAP_MAX);
    check(cap_f[0] == 1'b0, "R1 left first", cap_f[0], 0);
    check_wave("R1 fclk", 1, 0, n, n/2);
    check_wave("R2 bclk", 0, 0, n / (b ? 64 : 32), n / (b ? 128 : 64));
    for (int k = 1; k < CAP_MAX; k++)
      if (cap_f[k] != cap_f[k-1] && !(cap_b[k-1] == 1'b1 && cap_b[k] == 1'b0)) bad++;
    check(bad == 0, "R3 frame edge on bclk fall", bad, 0);
    bad = 0;
    for (int k = 0; k < CAP_MAX; k++) if (cap_m[k]) bad++;
    check(bad == 0, "R6 mco disabled", bad, 0);
  endtask

  task automatic t_mco(input logic [1:0] i, input logic [1:0] o);
    int d = (ratio(i) << o) / 256;
    power_up(i, 1'b0, o, 1'b1);
    capture(CAP_MAX);
    check_wave("R4 mco", 2, 0, d, d/2);
  endtask

  task automatic t_pass(input logic e);
    int bad = 0;
    power_up(2'd0, 1'b0, 2'd0, e);
    repeat (6) @(posedge mclk);
    for (int k = 0; k < 40; k++) begin
      @(posedge mclk); #2;
      if (mco !== e) bad++;
      #5;
      if (mco !== 1'b0) bad++;
    end
    if (e) check(bad == 0, "R5 pass-through", bad, 0);
    else   check(bad == 0, "R6 pass-through disabled", bad, 0);
  endtask

  task automatic t_midframe();
    int r1, f1;
    power_up(2'd0, 1'b0, 2'd0, 1'b0);
    repeat (50) @(posedge mclk);
    #3; in_sel = 2'd1; bsel = 1'b1;
    capture(CAP_MAX);
    r1 = find_edge(1, 0, 1'b1);
    f1 = find_edge(1, r1, 1'b0);
    check(f1 - r1 == 128, "R7 old half frame kept", f1 - r1, 128);
    check(find_edge(1, f1, 1'b1) - f1 == 512, "R7 new half frame", find_edge(1, f1, 1'b1) - f1, 512);
    check_wave("R7 bclk before boundary", 0, 0, 8, 4);
    check_wave("R7 bclk after boundary", 0, f1, 16, 8);
  endtask

  task automatic t_powerdown();
    int bad = 0;
    power_up(2'd0, 1'b0, 2'd2, 1'b1);
    repeat (300) @(posedge mclk);
    #3; pwr = 1'b0;
    repeat (3) @(posedge mclk);
    for (int k = 0; k < 300; k++) begin
      @(posedge mclk); #2;
      if ({bclk, fclk, mco} != 3'b000) bad++;
      #5;
      if ({bclk, fclk, mco} != 3'b000) bad++;
    end
    check(bad == 0, "R8 powered down outputs low", bad, 0);
    #1; pwr = 1'b1;
    capture(CAP_MAX);
    check(find_edge(1, 0, 1'b1) == 128, "R8 restart from zero", find_edge(1, 0, 1'b1), 128);
  endtask

  task automatic t_async_reset();
    power_up(2'd1, 1'b1, 2'd1, 1'b1);
    repeat (700) @(posedge mclk);
    #3; rst_n = 1'b0;
    #1;
    check({bclk, fclk, mco} == 3'b000, "R9 async reset", {bclk, fclk, mco}, 0);
    #10; rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge mclk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_ratio(2'd0, 1'b0);
    t_ratio(2'd0, 1'b1);
    t_ratio(2'd1, 1'b0);
    t_ratio(2'd2, 1'b1);
    t_ratio(2'd3, 1'b0);
    t_ratio(2'd3, 1'b1);
    t_mco(2'd0, 2'd1);
    t_mco(2'd0, 2'd3);
    t_mco(2'd1, 2'd0);
    t_mco(2'd2, 2'd2);
    t_mco(2'd1, 2'd3);
    t_pass(1'b1);
    t_pass(1'b0);
    t_midframe();
    t_powerdown();
    t_async_reset();
    finish_run();
  end

endmodule